// File: doc/BRIEF.md
# BCD Calendar and Time-of-Day Counter Chain

This block holds wall-clock time and the calendar date as packed BCD digit pairs: seconds, minutes and hours, then day of month, month and a four-digit year. A single-cycle enable pulse, one per second, advances the seconds. Each field hands a carry pulse to the next field when it wraps, so the chain runs seconds → minutes → hours → day → month → year. The day field follows the length of the current month, including the leap-year February.

Adjust logic can preset any one field in a given cycle through a synchronous load strobe. A load takes priority over counting for that field. All per-field carries are brought out so that neighbouring logic, such as an alarm compare or a display sequencer, can follow the cascade.

Top module: `bcd_calendar_chain`

## Requirements
- R1: A synchronous active-high reset sets the time to 00:00:00 and the date to 2000-01-01. Each two-digit field holds its units digit in bits [3:0] and its tens digit in bits [7:4]. The year holds its thousands digit in bits [15:12] and its units digit in bits [3:0].
- R2: Without a tick and without a load, every field holds its value.
- R3: On an advance, only the units digit increments while it is below 9. A units digit of 9 below the field's limit clears to 0 and the tens digit increments, so 09 becomes 10 and hour 19 becomes 20.
- R4: Seconds and minutes each wrap from 59 to 00. In the cycle of the wrap, the field's carry output is high, in the same cycle as the incoming advance, and it advances the next field.
- R5: Hours wrap from 23 to 00 with the hour carry high, and the wrap advances the day.
- R6: The day runs from 01 up to the current month's length, which is 31, 30 for months 04/06/09/11, or 28 for February. It then returns to 01 with the day carry high, and the month advances.
- R7: February has 29 days in a year divisible by 4, except a year divisible by 100 that is not divisible by 400.
- R8: The month runs from 01 to 12 and then returns to 01 with a carry that advances the year. The year counts in four BCD digits and wraps from 9999 to 0000 with the year carry high. The month and year change only on a carry from the field below them, or on a load.
- R9: When the load strobe is high, the selected field takes the load value on the next clock edge, and a loaded field raises no carry in that cycle. The select codes are 0 = seconds, 1 = minutes, 2 = hours, 3 = day, 4 = month and 5 = year. Two-digit fields take the load value's bits [7:0]. Codes 6 and 7 change nothing.
- R10: A field whose value is at or above its upper limit wraps to its start value with a carry on its next advance, so a day of 31 loaded into April becomes 01 of May.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance enable |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for the load |
| ld_val | input | 16 | BCD load value (bits [7:0] for two-digit fields) |
| sec_o | output | 8 | Seconds, packed BCD |
| min_o | output | 8 | Minutes, packed BCD |
| hour_o | output | 8 | Hours, packed BCD |
| day_o | output | 8 | Day of month, packed BCD |
| mon_o | output | 8 | Month, packed BCD |
| year_o | output | 16 | Year, four BCD digits |
| sec_cy | output | 1 | Seconds wrap carry |
| min_cy | output | 1 | Minutes wrap carry |
| hour_cy | output | 1 | Hours wrap carry |
| day_cy | output | 1 | Day wrap carry |
| mon_cy | output | 1 | Month wrap carry |
| year_cy | output | 1 | Year wrap carry |

## Verification
A field load and a cascade advance can land on the same field in the same cycle. The bench provokes this by driving a tick while the seconds sit at 59 and, in that same cycle, loading either the seconds or the minutes. The scoreboard model expects the loaded value to win. When the seconds are loaded, it also expects no seconds carry and unchanged minutes. When the minutes are loaded while the seconds wrap, it expects the seconds at 00 and the minutes equal to the loaded value.

// File: rtl/cal_pkg.sv
package cal_pkg;
   typedef enum logic [2:0] {
      FLD_SEC  = 3'd0,
      FLD_MIN  = 3'd1,
      FLD_HOUR = 3'd2,
      FLD_DAY  = 3'd3,
      FLD_MON  = 3'd4,
      FLD_YEAR = 3'd5
   } field_e;

   localparam int NUM_FIELDS = 6;
   localparam int SEL_W      = 3;

   // divisibility by 4 of a packed two-digit BCD number
   function automatic logic bcd_div4(input logic [7:0] b);
      logic [3:0] u;
      u = b[3:0];
      if (b[4] == 1'b0) return (u == 4'd0) || (u == 4'd4) || (u == 4'd8);
      else              return (u == 4'd2) || (u == 4'd6);
   endfunction
endpackage

// File: rtl/cal_bcd2_counter.sv
module cal_bcd2_counter #(
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       ld,
   input  logic [7:0] ld_val,
   input  logic [7:0] lo,
   input  logic [7:0] hi,
   output logic [7:0] val,
   output logic       cy
);
   logic       at_end;
   logic [7:0] nxt;

   always_comb begin
      at_end = (val >= hi);
      cy     = en & ~ld & at_end;
      if (at_end)                 nxt = lo;
      else if (val[3:0] == 4'd9)  nxt = {val[7:4] + 4'd1, 4'd0};
      else                        nxt = {val[7:4], val[3:0] + 4'd1};
   end

   always_ff @(posedge clk) begin
      if (rst)     val <= RST_VAL;
      else if (ld) val <= ld_val;
      else if (en) val <= nxt;
   end
endmodule

// File: rtl/cal_bcd_digits_counter.sv
module cal_bcd_digits_counter #(
   parameter int DIGITS = 4,
   localparam int W = 4 * DIGITS,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         en,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] val,
   output logic         cy
);
   logic [DIGITS:0] run;
   logic [W-1:0]    nxt;

   assign run[0] = 1'b1;

   for (genvar i = 0; i < DIGITS; i++) begin : g_dig
      assign run[i+1] = run[i] & (val[4*i +: 4] == 4'd9);
      always_comb begin
         if (!run[i])                    nxt[4*i +: 4] = val[4*i +: 4];
         else if (val[4*i +: 4] == 4'd9) nxt[4*i +: 4] = 4'd0;
         else                            nxt[4*i +: 4] = val[4*i +: 4] + 4'd1;
      end
   end

   assign cy = en & ~ld & run[DIGITS];

   always_ff @(posedge clk) begin
      if (rst)     val <= RST_VAL;
      else if (ld) val <= ld_val;
      else if (en) val <= nxt;
   end
endmodule

// File: rtl/cal_month_len.sv
module cal_month_len (
   input  logic [7:0]  mon,
   input  logic [15:0] year,
   output logic [7:0]  len
);
   import cal_pkg::*;
   logic leap;

   always_comb begin
      // low pair 00 means a century: leap only if the high pair divides by 4
      if (year[7:0] == 8'h00) leap = bcd_div4(year[15:8]);
      else                    leap = bcd_div4(year[7:0]);
      unique case (mon)
         8'h02:                      len = leap ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: len = 8'h30;
         default:                    len = 8'h31;
      endcase
   end
endmodule

// File: rtl/bcd_calendar_chain.sv
module bcd_calendar_chain #(
   parameter int YEAR_DIGITS = 4,
   parameter logic [4*YEAR_DIGITS-1:0] RST_YEAR = 'h2000
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     tick,
   input  logic                     ld_en,
   input  logic [2:0]               ld_sel,
   input  logic [4*YEAR_DIGITS-1:0] ld_val,
   output logic [7:0]               sec_o,
   output logic [7:0]               min_o,
   output logic [7:0]               hour_o,
   output logic [7:0]               day_o,
   output logic [7:0]               mon_o,
   output logic [4*YEAR_DIGITS-1:0] year_o,
   output logic                     sec_cy,
   output logic                     min_cy,
   output logic                     hour_cy,
   output logic                     day_cy,
   output logic                     mon_cy,
   output logic                     year_cy
);
   import cal_pkg::*;
   localparam int YEAR_W = 4 * YEAR_DIGITS;

   if (YEAR_DIGITS < 4) begin : g_bad_digits
      $error("bcd_calendar_chain: YEAR_DIGITS must be at least 4");
   end

   logic [NUM_FIELDS-1:0] ld_hit;
   logic [7:0]            mlen;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_sel
      assign ld_hit[i] = ld_en && (ld_sel == SEL_W'(i));
   end

   cal_month_len u_len (.mon(mon_o), .year(year_o[15:0]), .len(mlen));

   cal_bcd2_counter #(.RST_VAL(8'h00)) u_sec (
      .clk, .rst, .en(tick), .ld(ld_hit[FLD_SEC]), .ld_val(ld_val[7:0]),
      .lo(8'h00), .hi(8'h59), .val(sec_o), .cy(sec_cy));

   cal_bcd2_counter #(.RST_VAL(8'h00)) u_min (
      .clk, .rst, .en(sec_cy), .ld(ld_hit[FLD_MIN]), .ld_val(ld_val[7:0]),
      .lo(8'h00), .hi(8'h59), .val(min_o), .cy(min_cy));

   cal_bcd2_counter #(.RST_VAL(8'h00)) u_hour (
      .clk, .rst, .en(min_cy), .ld(ld_hit[FLD_HOUR]), .ld_val(ld_val[7:0]),
      .lo(8'h00), .hi(8'h23), .val(hour_o), .cy(hour_cy));

   cal_bcd2_counter #(.RST_VAL(8'h01)) u_day (
      .clk, .rst, .en(hour_cy), .ld(ld_hit[FLD_DAY]), .ld_val(ld_val[7:0]),
      .lo(8'h01), .hi(mlen), .val(day_o), .cy(day_cy));

   cal_bcd2_counter #(.RST_VAL(8'h01)) u_mon (
      .clk, .rst, .en(day_cy), .ld(ld_hit[FLD_MON]), .ld_val(ld_val[7:0]),
      .lo(8'h01), .hi(8'h12), .val(mon_o), .cy(mon_cy));

   cal_bcd_digits_counter #(.DIGITS(YEAR_DIGITS), .RST_VAL(RST_YEAR)) u_year (
      .clk, .rst, .en(mon_cy), .ld(ld_hit[FLD_YEAR]), .ld_val(ld_val),
      .val(year_o), .cy(year_cy));
endmodule

// File: rtl/cal_chain_chk.sv
module cal_chain_chk #(
   parameter int YW = 16,
   parameter logic [YW-1:0] RST_YEAR = 'h2000
) (
   input logic          clk,
   input logic          rst,
   input logic          tick,
   input logic          ld_en,
   input logic [2:0]    ld_sel,
   input logic [YW-1:0] ld_val,
   input logic [7:0]    sec_o,
   input logic [7:0]    min_o,
   input logic [7:0]    hour_o,
   input logic [7:0]    day_o,
   input logic [7:0]    mon_o,
   input logic [YW-1:0] year_o,
   input logic          sec_cy,
   input logic          min_cy,
   input logic          hour_cy,
   input logic          day_cy,
   input logic          mon_cy,
   input logic          year_cy
);
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (sec_o == 8'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
               day_o == 8'h01 && mon_o == 8'h01 && year_o == RST_YEAR));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (!tick && !ld_en) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
                             $stable(day_o) && $stable(mon_o) && $stable(year_o)));

   assert_sec_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      sec_cy |=> sec_o == 8'h00);

   assert_min_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      min_cy |=> min_o == 8'h00);

   assert_hour_wrap_R5: assert property (@(posedge clk) disable iff (rst)
      hour_cy |=> hour_o == 8'h00);

   assert_day_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      day_cy |=> day_o == 8'h01);

   assert_mon_gate_R8: assert property (@(posedge clk) disable iff (rst)
      (!ld_en && !day_cy) |=> $stable(mon_o));

   assert_year_gate_R8: assert property (@(posedge clk) disable iff (rst)
      (!ld_en && !mon_cy) |=> $stable(year_o));

   assert_year_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      year_cy |=> year_o == '0);

   assert_load_hour_R9: assert property (@(posedge clk) disable iff (rst)
      (ld_en && ld_sel == 3'd2) |=> hour_o == $past(ld_val[7:0]));

   assert_load_no_carry_R9: assert property (@(posedge clk) disable iff (rst)
      (ld_en && ld_sel == 3'd0) |-> !sec_cy);
endmodule

bind bcd_calendar_chain cal_chain_chk #(.YW(4*YEAR_DIGITS), .RST_YEAR(RST_YEAR)) u_chk (.*);

// File: tb/sim_bcd_calendar_chain.sv
module sim_bcd_calendar_chain;
   localparam int CLK_PERIOD = 10;

   logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ld_en = 1'b0;
   logic [2:0]  ld_sel = 3'd0;
   logic [15:0] ld_val = 16'h0000;
   logic [7:0]  sec_o, min_o, hour_o, day_o, mon_o;
   logic [15:0] year_o;
   logic sec_cy, min_cy, hour_cy, day_cy, mon_cy, year_cy;

   bcd_calendar_chain u0 (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {string tag; int s; int m; int h; int d; int mo; int y;} snap_t;
   snap_t sb[$];
   int checks = 0, fails = 0;
   int ms = 0, mm = 0, mh = 0, md = 1, mmo = 1, my = 2000;
   bit done = 0;

   function automatic bit is_leap(int y);
      return ((y % 4 == 0) && (y % 100 != 0)) || (y % 400 == 0);
   endfunction
   function automatic int mlen(int mo, int y);
      if (mo == 2) return is_leap(y) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction
   function automatic logic [7:0] b2(int v);
      return {4'(v / 10), 4'(v % 10)};
   endfunction
   function automatic logic [15:0] b4(int v);
      return {4'(v / 1000), 4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
   endfunction

   task automatic chk(string tag, bit ok, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic adv(inout int v, input bit en, input bit ld, input int ldv,
                      input int lo, input int hi, output bit cy);
      cy = 1'b0;
      if (ld) v = ldv;
      else if (en) begin
         if (v >= hi) begin v = lo; cy = 1'b1; end
         else v = v + 1;
      end
   endtask

   // driver: one cycle of stimulus, model update, carry check, push expected
   task automatic step(string tag, bit tk, bit le, int sel, int val);
      bit c1, c2, c3, c4, c5, c6;
      int len;
      snap_t e;
      @(negedge clk);
      tick = tk; ld_en = le; ld_sel = sel[2:0];
      ld_val = (sel >= 5) ? b4(val) : {8'hA5, b2(val)};
      len = mlen(mmo, my);
      adv(ms,  tk, le && sel == 0, val, 0, 59, c1);
      adv(mm,  c1, le && sel == 1, val, 0, 59, c2);
      adv(mh,  c2, le && sel == 2, val, 0, 23, c3);
      adv(md,  c3, le && sel == 3, val, 1, len, c4);
      adv(mmo, c4, le && sel == 4, val, 1, 12, c5);
      adv(my,  c5, le && sel == 5, val, 0, 9999, c6);
      #1;
      chk(tag, {sec_cy, min_cy, hour_cy, day_cy, mon_cy, year_cy} ==
               {c1, c2, c3, c4, c5, c6}, "carries",
          int'({sec_cy, min_cy, hour_cy, day_cy, mon_cy, year_cy}),
          int'({c1, c2, c3, c4, c5, c6}));
      @(posedge clk);
      e.tag = tag; e.s = ms; e.m = mm; e.h = mh; e.d = md; e.mo = mmo; e.y = my;
      sb.push_back(e);
   endtask

   task automatic set_all(int h, int m, int s, int d, int mo, int y);
      step("R9", 0, 1, 5, y);
      step("R9", 0, 1, 4, mo);
      step("R9", 0, 1, 3, d);
      step("R9", 0, 1, 2, h);
      step("R9", 0, 1, 1, m);
      step("R9", 0, 1, 0, s);
   endtask

   // monitor: compare registered fields one cycle after each driven step
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         snap_t e;
         e = sb.pop_front();
         chk(e.tag, sec_o == b2(e.s), "sec", int'(sec_o), int'(b2(e.s)));
         chk(e.tag, min_o == b2(e.m) && hour_o == b2(e.h), "min:hour",
             int'({hour_o, min_o}), int'({b2(e.h), b2(e.m)}));
         chk(e.tag, day_o == b2(e.d) && mon_o == b2(e.mo), "mon-day",
             int'({mon_o, day_o}), int'({b2(e.mo), b2(e.d)}));
         chk(e.tag, year_o == b4(e.y), "year", int'(year_o), int'(b4(e.y)));
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1", {hour_o, min_o, sec_o} == 24'h000000, "time", int'({hour_o, min_o, sec_o}), 0);
      chk("R1", {year_o, mon_o, day_o} == 32'h20000101, "date",
          int'({year_o, mon_o, day_o}), 32'h20000101);
      rst = 1'b0;
      repeat (3) step("R2", 0, 0, 0, 0);
      for (int i = 0; i < 20; i++) step("R3", 1, 0, 0, 0);
      for (int i = 0; i < 55; i++) step("R4", 1, 0, 0, 0);
      step("R2", 0, 0, 0, 0);
      set_all(19, 59, 59, 15, 6, 2023);  step("R3", 1, 0, 0, 0);
      set_all(23, 59, 59, 10, 6, 2023);  step("R5", 1, 0, 0, 0);
      set_all(23, 59, 59, 30, 4, 2023);  step("R6", 1, 0, 0, 0);
      set_all(23, 59, 59, 28, 2, 2023);  step("R6", 1, 0, 0, 0);
      set_all(23, 59, 59, 28, 2, 2024);  step("R7", 1, 0, 0, 0);
      set_all(23, 59, 59, 29, 2, 2024);  step("R7", 1, 0, 0, 0);
      set_all(23, 59, 59, 28, 2, 1900);  step("R7", 1, 0, 0, 0);
      set_all(23, 59, 59, 28, 2, 2000);  step("R7", 1, 0, 0, 0);
      set_all(23, 59, 59, 28, 2, 2100);  step("R7", 1, 0, 0, 0);
      set_all(23, 59, 59, 31, 12, 1999); step("R8", 1, 0, 0, 0);
      set_all(23, 59, 59, 31, 12, 9999); step("R8", 1, 0, 0, 0);
      // R9 unused select codes leave every field untouched
      step("R9", 0, 1, 6, 1234);
      step("R9", 0, 1, 7, 4321);
      // R9 load beats counting on the same field in the same cycle
      set_all(12, 7, 59, 3, 3, 2022);    step("R9", 1, 1, 0, 30);
      set_all(12, 7, 59, 3, 3, 2022);    step("R9", 1, 1, 1, 40);
      set_all(12, 59, 59, 3, 3, 2022);   step("R9", 1, 1, 1, 20);
      // R10 out-of-range day wraps on the next advance
      set_all(23, 59, 59, 31, 4, 2023);  step("R10", 1, 0, 0, 0);
      step("R2", 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule